// File: doc/BRIEF.md
# Row/Column Scanning Event Readout

This block reads events out of a two-dimensional array of event-generating cells. Every cell raises a one-cycle pulse on its own input bit when it has an event. The block keeps one pending flag per cell. A row counter and a column counter visit the cells in a fixed, repeating order.

The scan moves one position per external sample tick and does not depend on how busy the cells are. When the selected cell holds a pending event, the block puts that cell's address on the output channel. It then runs a four-phase request/acknowledge exchange with the receiver and clears the flag. Only then does it move on. When the selected cell holds no event, the block moves on at once.

Only the selected cell can reach the channel, so two events never collide on it. A cell that has not yet been served keeps its event. A second event that reaches a cell whose flag is still set is lost. Each such loss is counted in a saturating counter.

Top module: `scan_event_readout`

## Requirements
- R1: After reset, req is low, addr is zero, sat_count is zero, and the scan position is row 0, column 0.
- R2: The column index advances on every scan step. The row index advances only when the column wraps from COLS-1 to 0, and the position wraps from (ROWS-1, COLS-1) back to (0,0). Cell index = row*COLS + col.
- R3: A sample_tick at a position with no pending flag advances the position by one step, in the same cycle, and raises no request. While sample_tick is low in the scan state, the position does not change.
- R4: A sample_tick at a position whose flag is set raises req in the next cycle. addr = {row, col}, with the column in the low CW bits. req and addr hold while ack is low.
- R5: When ack is seen high during a request, req drops in the next cycle and the cell's flag is cleared. The position advances only after ack is then seen low. It never moves while req is high.
- R6: Events at cells that are not selected stay pending until the scan reaches them. Several pending cells are served in scan order, one sample tick per position.
- R7: addr reads zero whenever req is low.
- R8: An event pulse at a cell whose flag is already set, and is not being cleared in that cycle, adds one to sat_count. Simultaneous pulses at several such cells add one each. Pulses at clear cells add nothing.
- R9: sat_count stops at its all-ones value and never wraps.
- R10: A cell that has been served is not requested again until it receives a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Scan pacing strobe from the external sampling clock |
| cell_ev | input | ROWS*COLS | One-cycle event pulse per cell, bit index row*COLS+col |
| ack | input | 1 | Acknowledge from the receiver |
| req | output | 1 | Request: addr carries a valid event |
| addr | output | RW+CW | Event address {row, col}, zero while req is low |
| sat_count | output | SAT_W | Saturating count of events lost to full flags |

## Verification
On every cycle, the assertions check the following:
- the counter stepping and wrap order;
- that the position freezes without a step;
- that a request only starts from a pending flag;
- that addr holds while a request waits;
- that req drops after ack;
- that a clear only hits a set flag;
- that the loss counter never falls.

Only the bench scenarios can show the end-to-end behaviour:
- the exact count of idle ticks before a distant cell is served, swept over every distance;
- events held across a stalled handshake;
- the loss counts for repeated and simultaneous pulses, including the clamp;
- that a served cell stays silent for a whole sweep.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    HS_SCAN = 2'd0,
    HS_REQ  = 2'd1,
    HS_REL  = 2'd2
  } hs_state_t;

  // Linear cell index from a scan position
  function automatic int unsigned cell_index(input int unsigned r,
                                             input int unsigned c,
                                             input int unsigned ncols);
    return r * ncols + c;
  endfunction

  // Index width that stays legal for a count of one
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/scan_position.sv
module scan_position #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int RW   = 2,
  parameter int CW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col
);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  logic col_wrap;
  assign col_wrap = (col == COL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (step) begin
      if (col_wrap) begin
        col <= '0;
        row <= (row == ROW_LAST) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(row) && $stable(col))); // R3
  AST_COL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (step && col != COL_LAST) |=> (col == $past(col) + 1'b1 && $stable(row))); // R2
  AST_ROW_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && col == COL_LAST) |=> (col == '0 && row != $past(row || ROWS == 1 ? row : ~row))); // R2
  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (row <= ROW_LAST && col <= COL_LAST)); // R2

endmodule

// File: rtl/event_store.sv
module event_store #(
  parameter int CELLS = 16,
  parameter int IW    = 4,
  parameter int SAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CELLS-1:0] cell_ev,
  input  logic [IW-1:0]    sel_idx,
  input  logic             clr_en,
  output logic             pending_sel,
  output logic [SAT_W-1:0] sat_count
);
  localparam int HW = $clog2(CELLS + 1);
  localparam int SUM_W = SAT_W + HW + 1;
  localparam logic [SAT_W-1:0] SAT_MAX = '1;

  logic [CELLS-1:0] flags;
  logic [CELLS-1:0] clr_vec;
  logic [CELLS-1:0] lost_vec;
  logic [HW-1:0]    lost_cnt;
  logic [SUM_W-1:0] sat_sum;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign clr_vec[i]  = clr_en && (sel_idx == IW'(i));
    assign lost_vec[i] = cell_ev[i] && flags[i] && !clr_vec[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= (flags[i] && !clr_vec[i]) || cell_ev[i];
    end
  end

  always_comb begin
    lost_cnt = '0;
    for (int i = 0; i < CELLS; i++) lost_cnt = lost_cnt + HW'(lost_vec[i]);
  end

  assign sat_sum = SUM_W'(sat_count) + SUM_W'(lost_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         sat_count <= '0;
    else if (sat_sum > SUM_W'(SAT_MAX)) sat_count <= SAT_MAX;
    else                                sat_count <= sat_sum[SAT_W-1:0];
  end

  assign pending_sel = flags[sel_idx];

  AST_CLEAR_ON_SET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> pending_sel); // R5
  AST_SAT_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sat_count >= $past(sat_count))); // R9
  AST_SAT_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_vec != '0 && sat_count != SAT_MAX) |=> (sat_count != $past(sat_count))); // R8

endmodule

// File: rtl/handshake_ctrl.sv
module handshake_ctrl
  import scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick,
  input  logic pending,
  input  logic ack,
  output logic req,
  output logic clr_en,
  output logic step
);
  hs_state_t state, state_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= HS_SCAN;
    else        state <= state_nxt;
  end

  always_comb begin
    state_nxt = state;
    step      = 1'b0;
    clr_en    = 1'b0;
    unique case (state)
      HS_SCAN: if (sample_tick) begin
        if (pending) state_nxt = HS_REQ;
        else         step      = 1'b1;
      end
      HS_REQ: if (ack) begin
        clr_en    = 1'b1;
        state_nxt = HS_REL;
      end
      HS_REL: if (!ack) begin
        step      = 1'b1;
        state_nxt = HS_SCAN;
      end
      default: state_nxt = HS_SCAN;
    endcase
  end

  assign req = (state == HS_REQ);

  AST_REQ_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(pending && sample_tick)); // R4
  AST_REQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=> !req); // R5
  AST_NO_STEP_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !step); // R5

endmodule

// File: rtl/scan_event_readout.sv
module scan_event_readout
  import scan_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int SAT_W = 8,
  localparam int CELLS = ROWS * COLS,
  localparam int RW    = idx_width(ROWS),
  localparam int CW    = idx_width(COLS),
  localparam int IW    = idx_width(CELLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic [CELLS-1:0] cell_ev,
  input  logic             ack,
  output logic             req,
  output logic [RW+CW-1:0] addr,
  output logic [SAT_W-1:0] sat_count
);
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [IW-1:0] sel_idx;
  logic          step;
  logic          clr_en;
  logic          pending_sel;

  scan_position #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_pos (
    .clk(clk), .rst_n(rst_n), .step(step), .row(row), .col(col)
  );

  assign sel_idx = IW'(cell_index(int'(row), int'(col), COLS));

  event_store #(.CELLS(CELLS), .IW(IW), .SAT_W(SAT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cell_ev(cell_ev), .sel_idx(sel_idx),
    .clr_en(clr_en), .pending_sel(pending_sel), .sat_count(sat_count)
  );

  handshake_ctrl u_hs (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .pending(pending_sel),
    .ack(ack), .req(req), .clr_en(clr_en), .step(step)
  );

  assign addr = req ? {row, col} : '0;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(addr))); // R4
  AST_ADDR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (addr == '0)); // R7

endmodule

// File: tb/tb_scan_event_readout.sv
module tb_scan_event_readout;
  localparam int ROWS = 3, COLS = 5, SAT_W = 4;
  localparam int N = ROWS * COLS;
  localparam int CW = 3;

  logic clk = 1'b0, rst_n = 1'b0, sample_tick = 1'b0, ack = 1'b0;
  logic [N-1:0] cell_ev = '0;
  logic req;
  logic [4:0] addr;
  logic [SAT_W-1:0] sat_count;

  int total = 0, bad = 0, pos = 0, n = 0;
  bit done = 0;

  scan_event_readout #(.ROWS(ROWS), .COLS(COLS), .SAT_W(SAT_W)) dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .cell_ev(cell_ev),
    .ack(ack), .req(req), .addr(addr), .sat_count(sat_count)
  );

  always #5 clk = ~clk;

  function automatic int exp_addr(input int idx);
    return ((idx / COLS) << CW) | (idx % COLS);
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic pulse(input int idx);
    cell_ev = '0; cell_ev[idx] = 1'b1; cyc(); cell_ev = '0;
  endtask

  task automatic wait_req(output int cnt);
    cnt = 0;
    while (!req && cnt < 100) begin cyc(); cnt++; end
  endtask

  task automatic finish_hs();
    ack = 1'b1; cyc();
    chk(req == 1'b0, "R5 req drop after ack", int'(req), 0);
    ack = 1'b0; cyc();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1; cyc();
    // R1 reset state
    chk(req == 0, "R1 req", int'(req), 0);
    chk(addr == 0, "R1 addr", int'(addr), 0);
    chk(sat_count == 0, "R1 sat", int'(sat_count), 0);

    // R2 R6: all cells pending, served in scan order starting at (0,0)
    cell_ev = '1; cyc(); cell_ev = '0;
    sample_tick = 1'b1;
    for (int k = 0; k < N; k++) begin
      wait_req(n);
      chk(n == 1, "R6 no idle gap", n, 1);
      chk(addr == 5'(exp_addr(k)), "R2 scan order addr", int'(addr), exp_addr(k));
      finish_hs();
    end
    chk(sat_count == 0, "R8 no loss on clear cells", int'(sat_count), 0);
    pos = 0;

    // R3 R6: idle stepping, every distance
    for (int d = 0; d < N; d++) begin
      int tgt;
      tgt = (pos + d) % N;
      sample_tick = 1'b0; pulse(tgt); sample_tick = 1'b1;
      wait_req(n);
      chk(n == d + 1, "R3 idle ticks before service", n, d + 1);
      chk(addr == 5'(exp_addr(tgt)), "R4 addr of target", int'(addr), exp_addr(tgt));
      finish_hs();
      pos = (tgt + 1) % N;
    end

    // R3: no tick, no progress
    sample_tick = 1'b0; pulse(pos);
    for (int i = 0; i < 10; i++) begin
      cyc();
      chk(req == 0, "R3 no tick no request", int'(req), 0);
    end
    sample_tick = 1'b1;
    wait_req(n);
    chk(n == 1, "R4 request next cycle", n, 1);
    finish_hs();
    pos = (pos + 1) % N;

    // R4 R5 R6: stalled handshake, other event held
    begin
      int q;
      q = (pos + 2) % N;
      sample_tick = 1'b0; pulse(pos); sample_tick = 1'b1;
      wait_req(n);
      for (int i = 0; i < 12; i++) begin
        if (i == 3) begin cell_ev[q] = 1'b1; cyc(); cell_ev = '0; end
        else cyc();
        chk(req == 1 && addr == 5'(exp_addr(pos)), "R4 held during stall",
            int'(addr), exp_addr(pos));
      end
      finish_hs();
      wait_req(n);
      chk(n == 2, "R5 advance only after release", n, 2);
      chk(addr == 5'(exp_addr(q)), "R6 held event served", int'(addr), exp_addr(q));
      finish_hs();
      pos = (q + 1) % N;
    end

    // R10 R7: full sweep with nothing pending
    for (int i = 0; i < N; i++) begin
      cyc();
      chk(req == 0, "R10 no repeat service", int'(req), 0);
      chk(addr == 0, "R7 addr zero when idle", int'(addr), 0);
    end

    // R8: saturation counting
    begin
      int a, b, c;
      a = (pos + 1) % N; b = (pos + 2) % N; c = (pos + 3) % N;
      sample_tick = 1'b0;
      pulse(a);
      chk(sat_count == 0, "R8 first event no loss", int'(sat_count), 0);
      pulse(a);
      chk(sat_count == 1, "R8 repeat event lost", int'(sat_count), 1);
      pulse(b);
      cell_ev[a] = 1; cell_ev[b] = 1; cell_ev[c] = 1; cyc(); cell_ev = '0;
      chk(sat_count == 3, "R8 simultaneous losses", int'(sat_count), 3);
      sample_tick = 1'b1;
      wait_req(n);
      chk(n == 2 && addr == 5'(exp_addr(a)), "R6 first saturated cell", int'(addr), exp_addr(a));
      finish_hs();
      wait_req(n);
      chk(n == 1 && addr == 5'(exp_addr(b)), "R6 second cell", int'(addr), exp_addr(b));
      finish_hs();
      wait_req(n);
      chk(n == 1 && addr == 5'(exp_addr(c)), "R6 third cell", int'(addr), exp_addr(c));
      finish_hs();
      pos = (c + 1) % N;
      chk(sat_count == 3, "R8 service keeps count", int'(sat_count), 3);
    end

    // R9: clamp at all ones
    sample_tick = 1'b0;
    for (int i = 0; i < 21; i++) pulse(pos);
    chk(sat_count == 15, "R9 clamp", int'(sat_count), 15);
    sample_tick = 1'b1;
    wait_req(n);
    chk(n == 1, "R10 single service after losses", n, 1);
    finish_hs();
    pos = (pos + 1) % N;
    for (int i = 0; i < N; i++) begin
      cyc();
      chk(req == 0, "R10 lost events not replayed", int'(req), 0);
    end
    chk(sat_count == 15, "R9 clamp holds", int'(sat_count), 15);

    summary();
  end
endmodule